// File: doc/BRIEF.md
# Legacy PC System Control Ports

This block is a small register file for a handful of fixed byte-wide I/O ports that legacy PC firmware expects to find on the motherboard. It sits on a single-cycle bus: the host drives an address together with a write or read strobe. Write data is captured at the clock edge that ends the cycle. Read data and the hit flag are combinational within the cycle.

The block holds the speaker data enable and the gate of timer channel 2. It reports the timer's channel-2 output and a refresh status bit that flips on every read. It also keeps the A20 address-line enable and the coprocessor-error interrupt request. A diagnostic port accepts writes and discards them.

A power-off port watches the bytes written to it for the ASCII word `Shutdown`. It tracks its progress with a state machine that has one state per expected character:

| State | Expected byte |
|-------|---------------|
| PW_S | `S` (0x53) |
| PW_H | `h` (0x68) |
| PW_U | `u` (0x75) |
| PW_T | `t` (0x74) |
| PW_D | `d` (0x64) |
| PW_O | `o` (0x6F) |
| PW_W | `w` (0x77) |
| PW_N | `n` (0x6E) |

The machine makes three transitions, each taken only on a write to the power-off port:

- **advance**: the byte matches, so the machine moves to the next state.
- **wrap**: the byte matches in PW_N, so the machine returns to PW_S and fires the shutdown pulse.
- **miss**: the byte does not match, so the machine returns to PW_S without testing that byte again.

Top module: `sysctl_ports`

## Requirements
- R1: A write to address 0x0061 loads the timer-2 gate from data bit 0 and the speaker enable from data bit 1. No other access changes either output.
- R2: A read of 0x0061 returns the following, with bits 2, 3, 6 and 7 reading zero:
  - bit 0: the timer-2 gate
  - bit 1: the speaker enable
  - bit 4: the refresh bit
  - bit 5: the live timer-2 output input
- R3: Each read of 0x0061 inverts the refresh bit, and that read returns the inverted value. No other access changes the refresh bit.
- R4: A write to 0x0092 loads the A20 enable from data bit 1 and ignores bit 0. A read of 0x0092 returns the A20 enable in bit 1 and zero in every other bit.
- R5: A one-cycle pulse on the FPU error input raises the IRQ13 request. Any write to 0x00F0 lowers it. When both happen in the same cycle, the request stays raised.
- R6: Writes to 0x0080 change no output and no readable state.
- R7: Writing the eight bytes 0x53 0x68 0x75 0x74 0x64 0x6F 0x77 0x6E to 0x8900 in order raises the shutdown output for exactly one clock, in the cycle after the eighth write.
- R8: A mismatching byte written to 0x8900 returns the matcher to PW_S, and that byte is not tested again as a first character.
- R9: After a completed sequence the matcher is back in PW_S, so a second full sequence fires a second pulse.
- R10: The hit output is high for any write to one of the five claimed addresses and for a read of 0x0061 or 0x0092. For any other access it is low, and such a read returns 0x00.
- R11: After synchronous reset the following are all zero, and the first read of 0x0061 returns 0x10 when the timer input is low:
  - the timer-2 gate, speaker enable, A20 enable, IRQ13 request and shutdown output
  - the refresh bit
  - the matcher, which starts in PW_S
- R12: Accesses to other addresses between power-off bytes neither advance nor reset the matcher.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 16 | I/O address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| hit_o | output | 1 | Access hit a claimed port |
| tmr2_out_i | input | 1 | Timer channel-2 output |
| fpu_err_i | input | 1 | FPU error event pulse |
| tmr2_gate_o | output | 1 | Timer channel-2 gate |
| spk_en_o | output | 1 | Speaker data enable |
| a20_en_o | output | 1 | A20 address-line enable |
| irq13_o | output | 1 | Coprocessor-error interrupt request |
| shutdown_o | output | 1 | One-cycle power-off request |

## Verification
The matcher's state cannot be seen at the ports; only the final pulse reveals it. The hardest cases are therefore a miss that happens to carry a valid first character, and a sequence broken up by traffic to other ports.

The stimulus writes `S S h u t d o w n`, which must not fire. It writes a sequence whose last byte is wrong, followed by a clean one. It also splits a sequence with accesses to other ports. In each case the number of shutdown pulses is counted on the opposite clock edge.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PW_S,
        PW_H,
        PW_U,
        PW_T,
        PW_D,
        PW_O,
        PW_W,
        PW_N
    } pw_state_t;
endpackage

// File: rtl/sc_spkr_reg.sv
module sc_spkr_reg
    import sysctl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              tmr2_out_i,
    output logic              gate_o,
    output logic              spk_o,
    output logic [BYTE_W-1:0] rdata_o
);
    logic gate_q;
    logic spk_q;
    logic refresh_q;
    logic unused_wbits;

    assign unused_wbits = ^wdata_i[BYTE_W-1:2];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gate_q    <= 1'b0;
            spk_q     <= 1'b0;
            refresh_q <= 1'b0;
        end else begin
            if (wr_en_i) begin
                gate_q <= wdata_i[0];
                spk_q  <= wdata_i[1];
            end
            if (rd_en_i) begin
                refresh_q <= ~refresh_q;
            end
        end
    end

    always_comb begin
        rdata_o    = '0;
        rdata_o[0] = gate_q;
        rdata_o[1] = spk_q;
        rdata_o[4] = ~refresh_q;
        rdata_o[5] = tmr2_out_i;
    end

    assign gate_o = gate_q;
    assign spk_o  = spk_q;
endmodule

// File: rtl/sc_a20_reg.sv
module sc_a20_reg
    import sysctl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic              a20_o,
    output logic [BYTE_W-1:0] rdata_o
);
    logic a20_q;
    logic unused_wbits;

    assign unused_wbits = ^{wdata_i[BYTE_W-1:2], wdata_i[0]};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            a20_q <= 1'b0;
        end else if (wr_en_i) begin
            a20_q <= wdata_i[1];
        end
    end

    always_comb begin
        rdata_o    = '0;
        rdata_o[1] = a20_q;
    end

    assign a20_o = a20_q;
endmodule

// File: rtl/sc_fpu_irq.sv
module sc_fpu_irq (
    input  logic clk_i,
    input  logic rst_i,
    input  logic err_i,
    input  logic clr_i,
    output logic irq_o
);
    logic irq_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_q <= 1'b0;
        end else if (err_i) begin
            irq_q <= 1'b1;
        end else if (clr_i) begin
            irq_q <= 1'b0;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/sc_pwroff_fsm.sv
module sc_pwroff_fsm
    import sysctl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic              shutdown_o
);
    pw_state_t         state_q;
    pw_state_t         state_d;
    pw_state_t         advance_st;
    logic [BYTE_W-1:0] want_ch;
    logic              last_ch;
    logic              match;
    logic              pulse_q;

    // expected character and successor for each state
    always_comb begin
        want_ch    = 8'h00;
        advance_st = PW_S;
        last_ch    = 1'b0;
        unique case (state_q)
            PW_S: begin want_ch = 8'h53; advance_st = PW_H; end
            PW_H: begin want_ch = 8'h68; advance_st = PW_U; end
            PW_U: begin want_ch = 8'h75; advance_st = PW_T; end
            PW_T: begin want_ch = 8'h74; advance_st = PW_D; end
            PW_D: begin want_ch = 8'h64; advance_st = PW_O; end
            PW_O: begin want_ch = 8'h6F; advance_st = PW_W; end
            PW_W: begin want_ch = 8'h77; advance_st = PW_N; end
            PW_N: begin want_ch = 8'h6E; advance_st = PW_S; last_ch = 1'b1; end
            default: begin want_ch = 8'h00; advance_st = PW_S; end
        endcase
    end

    assign match = (wdata_i == want_ch);

    // transitions: advance, wrap (match in PW_N), miss (back to PW_S)
    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            state_d = match ? advance_st : PW_S;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PW_S;
        end else begin
            state_q <= state_d;
        end
    end

    // output process: registered one-cycle pulse on wrap
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wr_en_i && match && last_ch;
        end
    end

    assign shutdown_o = pulse_q;
endmodule

// File: rtl/sysctl_ports.sv
module sysctl_ports
    import sysctl_pkg::*;
#(
    parameter int              AW          = 16,
    parameter logic [AW-1:0]   ADDR_SPKR   = 16'h0061,
    parameter logic [AW-1:0]   ADDR_A20    = 16'h0092,
    parameter logic [AW-1:0]   ADDR_FPUCLR = 16'h00F0,
    parameter logic [AW-1:0]   ADDR_POST   = 16'h0080,
    parameter logic [AW-1:0]   ADDR_PWROFF = 16'h8900
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [AW-1:0]     addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              hit_o,
    input  logic              tmr2_out_i,
    input  logic              fpu_err_i,
    output logic              tmr2_gate_o,
    output logic              spk_en_o,
    output logic              a20_en_o,
    output logic              irq13_o,
    output logic              shutdown_o
);
    logic sel_spkr, sel_a20, sel_fclr, sel_post, sel_pwr;
    logic [BYTE_W-1:0] spkr_rd, a20_rd;

    assign sel_spkr = (addr_i == ADDR_SPKR);
    assign sel_a20  = (addr_i == ADDR_A20);
    assign sel_fclr = (addr_i == ADDR_FPUCLR);
    assign sel_post = (addr_i == ADDR_POST);
    assign sel_pwr  = (addr_i == ADDR_PWROFF);

    sc_spkr_reg u_spkr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_i && sel_spkr),
        .rd_en_i    (rd_i && sel_spkr),
        .wdata_i    (wdata_i),
        .tmr2_out_i (tmr2_out_i),
        .gate_o     (tmr2_gate_o),
        .spk_o      (spk_en_o),
        .rdata_o    (spkr_rd)
    );

    sc_a20_reg u_a20 (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_en_i (wr_i && sel_a20),
        .wdata_i (wdata_i),
        .a20_o   (a20_en_o),
        .rdata_o (a20_rd)
    );

    sc_fpu_irq u_irq (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .err_i (fpu_err_i),
        .clr_i (wr_i && sel_fclr),
        .irq_o (irq13_o)
    );

    sc_pwroff_fsm u_pwr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_i && sel_pwr),
        .wdata_i    (wdata_i),
        .shutdown_o (shutdown_o)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (sel_spkr) begin
                rdata_o = spkr_rd;
            end else if (sel_a20) begin
                rdata_o = a20_rd;
            end
        end
    end

    assign hit_o = (wr_i && (sel_spkr || sel_a20 || sel_fclr || sel_post || sel_pwr))
                || (rd_i && (sel_spkr || sel_a20));
endmodule

// File: rtl/sysctl_ports_chk.sv
module sysctl_ports_chk #(
    parameter int            AW          = 16,
    parameter logic [AW-1:0] ADDR_SPKR   = 16'h0061,
    parameter logic [AW-1:0] ADDR_A20    = 16'h0092,
    parameter logic [AW-1:0] ADDR_FPUCLR = 16'h00F0,
    parameter logic [AW-1:0] ADDR_PWROFF = 16'h8900
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic [AW-1:0] addr_i,
    input logic          wr_i,
    input logic          rd_i,
    input logic [7:0]    wdata_i,
    input logic [7:0]    rdata_o,
    input logic          hit_o,
    input logic          tmr2_out_i,
    input logic          fpu_err_i,
    input logic          tmr2_gate_o,
    input logic          a20_en_o,
    input logic          irq13_o,
    input logic          shutdown_o
);
    logic wr_spkr, rd_spkr, wr_a20, wr_fclr, wr_pwr;
    assign wr_spkr = wr_i && (addr_i == ADDR_SPKR);
    assign rd_spkr = rd_i && (addr_i == ADDR_SPKR);
    assign wr_a20  = wr_i && (addr_i == ADDR_A20);
    assign wr_fclr = wr_i && (addr_i == ADDR_FPUCLR);
    assign wr_pwr  = wr_i && (addr_i == ADDR_PWROFF);

    p_gate_hold_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_spkr |=> $stable(tmr2_gate_o));
    p_gate_load_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_spkr |=> tmr2_gate_o == $past(wdata_i[0]));
    p_rd_layout_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_spkr |-> (rdata_o[5] == tmr2_out_i) && (rdata_o[7:6] == 2'b00) && (rdata_o[3:2] == 2'b00));
    p_refresh_flip_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_spkr && $past(rd_spkr)) |-> rdata_o[4] != $past(rdata_o[4]));
    p_a20_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_a20 |=> $stable(a20_en_o));
    p_a20_load_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_a20 |=> a20_en_o == $past(wdata_i[1]));
    p_irq_set_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        fpu_err_i |=> irq13_o);
    p_irq_clr_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_fclr && !fpu_err_i) |=> !irq13_o);
    p_pulse_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        shutdown_o |=> !shutdown_o);
    p_pulse_cause_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(shutdown_o) |-> $past(wr_pwr && (wdata_i == 8'h6E)));
    p_miss_zero_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !hit_o) |-> rdata_o == 8'h00);
endmodule

bind sysctl_ports sysctl_ports_chk #(
    .AW          (AW),
    .ADDR_SPKR   (ADDR_SPKR),
    .ADDR_A20    (ADDR_A20),
    .ADDR_FPUCLR (ADDR_FPUCLR),
    .ADDR_PWROFF (ADDR_PWROFF)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .hit_o       (hit_o),
    .tmr2_out_i  (tmr2_out_i),
    .fpu_err_i   (fpu_err_i),
    .tmr2_gate_o (tmr2_gate_o),
    .a20_en_o    (a20_en_o),
    .irq13_o     (irq13_o),
    .shutdown_o  (shutdown_o)
);

// File: tb/sim_sysctl_ports.sv
module sim_sysctl_ports;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        hit;
    logic        tmr2 = 1'b0;
    logic        ferr = 1'b0;
    logic        gate, spk, a20, irq, sdn;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sysctl_ports u0 (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .hit_o(hit), .tmr2_out_i(tmr2),
        .fpu_err_i(ferr), .tmr2_gate_o(gate), .spk_en_o(spk), .a20_en_o(a20),
        .irq13_o(irq), .shutdown_o(sdn)
    );

    always @(negedge clk) if (sdn) pulses++;

    // {is_read, tmr2, addr[15:0], data[7:0], expected[7:0]}
    localparam int NV = 13;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h0061, 8'hFD, 8'h00},
        {1'b1, 1'b0, 16'h0061, 8'h00, 8'h11},
        {1'b1, 1'b1, 16'h0061, 8'h00, 8'h21},
        {1'b0, 1'b0, 16'h0061, 8'h02, 8'h00},
        {1'b1, 1'b1, 16'h0061, 8'h00, 8'h32},
        {1'b0, 1'b0, 16'h0092, 8'h01, 8'h00},
        {1'b1, 1'b0, 16'h0092, 8'h00, 8'h00},
        {1'b0, 1'b0, 16'h0092, 8'hFE, 8'h00},
        {1'b1, 1'b0, 16'h0092, 8'h00, 8'h02},
        {1'b0, 1'b0, 16'h0080, 8'hFF, 8'h00},
        {1'b1, 1'b0, 16'h0061, 8'h00, 8'h02},
        {1'b1, 1'b0, 16'h0092, 8'h00, 8'h02},
        {1'b1, 1'b0, 16'h1234, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, output logic [7:0] d, output logic h);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        d = rdata; h = hit;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic send_word(input logic [63:0] w);
        for (int i = 7; i >= 0; i--) do_wr(16'h8900, w[8*i +: 8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic h;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 reset gate/spk/a20/irq/sdn", {3'b0, gate, spk, a20, irq, sdn}, 8'h00);

        // table walk: R1 R2 R3 R4 R6 R10
        for (int i = 0; i < NV; i++) begin
            tmr2 = VEC[i][32];
            if (VEC[i][33]) begin
                do_rd(VEC[i][31:16], d, h);
                check("R2/R3/R4 table read", d, VEC[i][7:0]);
                check("R10 read hit", {7'b0, h},
                      {7'b0, (VEC[i][31:16] == 16'h0061) || (VEC[i][31:16] == 16'h0092)});
            end else begin
                do_wr(VEC[i][31:16], VEC[i][15:8]);
            end
        end
        tmr2 = 1'b0;
        check("R1 outputs after 0x02", {6'b0, spk, gate}, 8'h02);
        check("R4 a20 set", {7'b0, a20}, 8'h01);
        do_wr(16'h0061, 8'h01);
        check("R1 gate set spk clear", {6'b0, spk, gate}, 8'h01);
        do_wr(16'h0092, 8'h00);
        check("R4 a20 clear", {7'b0, a20}, 8'h00);

        // R5 IRQ13
        @(negedge clk); ferr = 1'b1;
        @(negedge clk); ferr = 1'b0;
        check("R5 irq raised", {7'b0, irq}, 8'h01);
        do_wr(16'h0080, 8'hA5);
        check("R6 post write leaves irq", {7'b0, irq}, 8'h01);
        check("R6 post write leaves gate/spk/a20", {5'b0, a20, spk, gate}, 8'h01);
        do_wr(16'h00F0, 8'h00);
        check("R5 irq cleared", {7'b0, irq}, 8'h00);
        @(negedge clk); addr = 16'h00F0; wr = 1'b1; ferr = 1'b1;
        @(negedge clk); wr = 1'b0; ferr = 1'b0;
        check("R5 set wins over clear", {7'b0, irq}, 8'h01);
        do_wr(16'h00F0, 8'h00);
        check("R5 irq cleared again", {7'b0, irq}, 8'h00);

        // R10 write hits
        @(negedge clk); addr = 16'h8900; wdata = 8'h00; wr = 1'b1; #1;
        check("R10 write hit power-off port", {7'b0, hit}, 8'h01);
        addr = 16'h1234; #1;
        check("R10 write miss", {7'b0, hit}, 8'h00);
        @(negedge clk); wr = 1'b0;

        // R7 full sequence
        base = pulses;
        for (int i = 7; i >= 0; i--) begin
            do_wr(16'h8900, 64'h53687574646F776E >> (8 * i));
            if (i == 0) check("R7 pulse after last byte", {7'b0, sdn}, 8'h01);
            else        check("R7 no early pulse", {7'b0, sdn}, 8'h00);
        end
        @(negedge clk);
        check("R7 pulse lasts one cycle", {7'b0, sdn}, 8'h00);
        check("R7 pulse count", 8'(pulses - base), 8'd1);

        // R8 miss not retested
        base = pulses;
        do_wr(16'h8900, 8'h53);
        send_word(64'h53687574646F776E);
        repeat (2) @(negedge clk);
        check("R8 SShutdown no pulse", 8'(pulses - base), 8'd0);
        send_word(64'h53687574646F7758);
        send_word(64'h53687574646F776E);
        repeat (2) @(negedge clk);
        check("R8 bad last byte then clean", 8'(pulses - base), 8'd1);

        // R9 back-to-back
        base = pulses;
        send_word(64'h53687574646F776E);
        send_word(64'h53687574646F776E);
        repeat (2) @(negedge clk);
        check("R9 two sequences two pulses", 8'(pulses - base), 8'd2);

        // R12 interleaved traffic
        base = pulses;
        do_wr(16'h8900, 8'h53); do_wr(16'h8900, 8'h68);
        do_wr(16'h8900, 8'h75); do_wr(16'h8900, 8'h74);
        do_wr(16'h0061, 8'h00); do_wr(16'h0080, 8'h53);
        do_rd(16'h0061, d, h);
        do_wr(16'h8900, 8'h64); do_wr(16'h8900, 8'h6F);
        do_wr(16'h8900, 8'h77); do_wr(16'h8900, 8'h6E);
        repeat (2) @(negedge clk);
        check("R12 interleaved still fires", 8'(pulses - base), 8'd1);

        // R11 reset state
        do_wr(16'h0061, 8'h03); do_wr(16'h0092, 8'h02);
        @(negedge clk); ferr = 1'b1;
        @(negedge clk); ferr = 1'b0;
        do_wr(16'h8900, 8'h53);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R11 outputs zero after reset", {3'b0, gate, spk, a20, irq, sdn}, 8'h00);
        do_rd(16'h0061, d, h);
        check("R11 first read after reset", d, 8'h10);
        base = pulses;
        send_word(64'h687574646F776E00);
        repeat (2) @(negedge clk);
        check("R11 matcher restarted", 8'(pulses - base), 8'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule